// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a synchronous DRAM interface. It brings the memory out of power-up in a fixed order and then keeps it refreshed for as long as the system runs. After reset it holds the command bus at no-operation for a long settling window. It then asks for a precharge of every bank, two auto refreshes and a load of the mode register. From then on it raises a refresh request at a steady pace, so that every row is refreshed within the retention period.

Every command goes out as a request to a command arbiter. A request holds until the arbiter grants it, and a command counts as issued in any cycle where the request and the grant are both high. Refresh intervals that pass while a request waits are counted, up to a limit, and are then served one after another. When the surrounding controller takes the memory out of self refresh, it pulses `sr_exit`. The sequencer then keeps the bus quiet for the exit window and restarts its refresh pacing. Every delay is a parameter in clock cycles, and the defaults are derived from the clock frequency.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is held: `cmd_req` is 0, `cmd_code` is the no-operation code 4'b0111, `cmd_addr` is 0, `busy` is 1 and `ready` is 0.
- R2: The first cycle after reset release counts as cycle 0. No request is raised in cycles 0 to PWRUP_CYC-1, and the first request appears in cycle PWRUP_CYC. A pulse on `sr_exit` during this window has no effect.
- R3: The first request is a precharge of all banks: `cmd_code` is 4'b0010, and `cmd_addr` has bit AP_BIT set and every other bit clear.
- R4: A raised request keeps `cmd_req`, `cmd_code` and `cmd_addr` unchanged in every cycle until the cycle in which `grant` is high. That cycle is the issue cycle.
- R5: After the precharge is issued, `cmd_req` stays low for exactly TRP_CYC cycles. Then exactly INIT_REFS auto refreshes (code 4'b0001, address 0) follow, each one followed by exactly TRFC_CYC cycles without a request.
- R6: After the last initial refresh wait, a load-mode request (code 4'b0000) is raised. Its address is the `mode_word` value sampled when the request is raised.
- R7: `ready` rises exactly TMRD_CYC+1 cycles after the load-mode issue cycle and stays high until reset. `busy` is high in every cycle before that and falls in the same cycle that `ready` rises.
- R8: Once `ready` is high, a refresh comes due every REFI_CYC cycles. With `grant` held high, the first periodic refresh request appears REFI_CYC+1 cycles after `ready` rises, and later ones appear REFI_CYC cycles apart.
- R9: Refreshes that come due while a request is not granted are counted, up to MAX_OWED. Further ones are dropped. Once granted, the counted refreshes issue back to back, TRFC_CYC+2 cycles apart, and no request follows the last of them until a new interval expires.
- R10: `sr_exit` is acted on only in a cycle where `ready` is high and `busy` is low. In the next TXSR_CYC cycles `busy` is high and `cmd_req` is low, and `busy` falls in the cycle after that. All owed refreshes are dropped and the pacing restarts, so the next refresh request appears REFI_CYC+2 cycles after the `sr_exit` cycle.
- R11: Whenever `cmd_req` is low, `cmd_code` is 4'b0111 and `cmd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_word | input | ADDR_W | Value to load into the memory's mode register |
| grant | input | 1 | The arbiter accepts the request raised in this cycle |
| sr_exit | input | 1 | One-cycle pulse: the memory has just left self refresh |
| cmd_req | output | 1 | A command is requested |
| cmd_code | output | 4 | Command code as {select, row strobe, column strobe, write enable}, active low |
| cmd_addr | output | ADDR_W | Address bus value for the requested command |
| busy | output | 1 | The sequencer is requesting, waiting out a delay, or not yet initialised |
| ready | output | 1 | Initialisation is complete |

## Verification
The bench builds the block with short delays: a 40-cycle power-up wait, precharge, refresh, mode and exit waits of 3, 5, 2 and 6 cycles, and a 100-cycle refresh interval. MAX_OWED stays at its default of 8. These values put the whole start-up order, and every wait length counted to the exact cycle, within a few hundred cycles. A grant held back for twelve intervals drives the owed counter well past its limit. The 100-cycle interval is long enough that the back-to-back service of eight refreshes finishes before the next interval ends, so the number of refreshes the bench expects is exact.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_PWRUP,
      ST_PRE,
      ST_TRP,
      ST_REF,
      ST_RFC,
      ST_LMR,
      ST_MRD,
      ST_IDLE,
      ST_XSR
   } seq_st_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
   parameter int REFI_CYC = 1562,
   parameter int MAX_OWED = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   input  logic svc,
   output logic owe_any
);

   localparam int IV_W = $clog2(REFI_CYC);

   logic [IV_W-1:0] iv_q;
   logic            due;

   assign due = en && (iv_q == IV_W'(REFI_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en || restart || due)
         iv_q <= '0;
      else
         iv_q <= iv_q + 1'b1;
   end

   generate
      if (MAX_OWED == 1) begin : g_flag
         logic owe_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart)
               owe_q <= 1'b0;
            else if (due)
               owe_q <= 1'b1;
            else if (svc)
               owe_q <= 1'b0;
         end
         assign owe_any = owe_q;
      end else begin : g_count
         localparam int OW_W = $clog2(MAX_OWED + 1);
         logic [OW_W-1:0] owed_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart)
               owed_q <= '0;
            else if (due && !svc && owed_q != OW_W'(MAX_OWED))
               owed_q <= owed_q + 1'b1;
            else if (svc && !due && owed_q != '0)
               owed_q <= owed_q - 1'b1;
         end
         assign owe_any = (owed_q != '0);
      end
   endgenerate

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
   import sdr_seq_pkg::*;
#(
   parameter int CLK_MHZ   = 100,
   parameter int ADDR_W    = 12,
   parameter int AP_BIT    = 10,
   parameter int INIT_REFS = 2,
   parameter int MAX_OWED  = 8,
   parameter int PWRUP_CYC = 100 * CLK_MHZ,
   parameter int TRP_CYC   = (20 * CLK_MHZ + 999) / 1000,
   parameter int TRFC_CYC  = (66 * CLK_MHZ + 999) / 1000,
   parameter int TMRD_CYC  = 2,
   parameter int TXSR_CYC  = (75 * CLK_MHZ + 999) / 1000,
   parameter int REFI_CYC  = (15625 * CLK_MHZ) / 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mode_word,
   input  logic              grant,
   input  logic              sr_exit,
   output logic              cmd_req,
   output logic [3:0]        cmd_code,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              busy,
   output logic              ready
);

   localparam int WAIT_MAX = max2(max2(PWRUP_CYC, TRP_CYC),
                                  max2(max2(TRFC_CYC, TMRD_CYC), TXSR_CYC));
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
   localparam int REF_W    = $clog2(INIT_REFS + 1);

   generate
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT must lie inside the address bus");
      end
      if (INIT_REFS < 1 || MAX_OWED < 1) begin : g_bad_cnt
         $error("INIT_REFS and MAX_OWED must be at least 1");
      end
      if (PWRUP_CYC < 1 || TRP_CYC < 1 || TRFC_CYC < 1 ||
          TMRD_CYC < 1 || TXSR_CYC < 1) begin : g_bad_wait
         $error("every wait must last at least one cycle");
      end
      if (REFI_CYC < TRFC_CYC + 3) begin : g_bad_refi
         $error("refresh interval too short for the refresh recovery");
      end
   endgenerate

   seq_st_e             st_q, st_nx;
   logic                tmr_load, tmr_expired;
   logic [WAIT_W-1:0]   tmr_val;
   logic [REF_W-1:0]    refs_left_q;
   logic [ADDR_W-1:0]   mode_q;
   logic                ready_q;
   logic                owe_any;
   logic                ref_issue, run_svc, sr_take;
   sdr_cmd_e            cmd_e;

   assign ref_issue = (st_q == ST_REF) && grant;
   assign run_svc   = ref_issue && ready_q;
   assign sr_take   = (st_q == ST_IDLE) && sr_exit;

   sdr_wait_timer #(
      .CNT_W   (WAIT_W),
      .RST_VAL (PWRUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdr_refresh_pacer #(
      .REFI_CYC (REFI_CYC),
      .MAX_OWED (MAX_OWED)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ready_q),
      .restart (sr_take),
      .svc     (run_svc),
      .owe_any (owe_any)
   );

   always_comb begin
      st_nx    = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_PWRUP: if (tmr_expired) st_nx = ST_PRE;
         ST_PRE: if (grant) begin
            st_nx    = ST_TRP;
            tmr_load = 1'b1;
            tmr_val  = WAIT_W'(TRP_CYC - 1);
         end
         ST_TRP: if (tmr_expired) st_nx = ST_REF;
         ST_REF: if (grant) begin
            st_nx    = ST_RFC;
            tmr_load = 1'b1;
            tmr_val  = WAIT_W'(TRFC_CYC - 1);
         end
         ST_RFC: if (tmr_expired) begin
            if (ready_q)                st_nx = ST_IDLE;
            else if (refs_left_q != '0) st_nx = ST_REF;
            else                        st_nx = ST_LMR;
         end
         ST_LMR: if (grant) begin
            st_nx    = ST_MRD;
            tmr_load = 1'b1;
            tmr_val  = WAIT_W'(TMRD_CYC - 1);
         end
         ST_MRD: if (tmr_expired) st_nx = ST_IDLE;
         ST_IDLE: begin
            if (sr_exit) begin
               st_nx    = ST_XSR;
               tmr_load = 1'b1;
               tmr_val  = WAIT_W'(TXSR_CYC - 1);
            end else if (owe_any) begin
               st_nx = ST_REF;
            end
         end
         ST_XSR: if (tmr_expired) st_nx = ST_IDLE;
         default: st_nx = ST_PWRUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_PWRUP;
         refs_left_q <= REF_W'(INIT_REFS);
         mode_q      <= '0;
         ready_q     <= 1'b0;
      end else begin
         st_q <= st_nx;
         if (ref_issue && !ready_q && refs_left_q != '0)
            refs_left_q <= refs_left_q - 1'b1;
         if (st_nx == ST_LMR && st_q != ST_LMR)
            mode_q <= mode_word;
         if (st_q == ST_MRD && tmr_expired)
            ready_q <= 1'b1;
      end
   end

   always_comb begin
      cmd_e    = CMD_NOP;
      cmd_addr = '0;
      unique case (st_q)
         ST_PRE: begin
            cmd_e            = CMD_PRE;
            cmd_addr[AP_BIT] = 1'b1;
         end
         ST_REF: cmd_e = CMD_REF;
         ST_LMR: begin
            cmd_e    = CMD_LMR;
            cmd_addr = mode_q;
         end
         default: cmd_e = CMD_NOP;
      endcase
   end

   assign cmd_req  = (st_q == ST_PRE) || (st_q == ST_REF) || (st_q == ST_LMR);
   assign cmd_code = cmd_e;
   assign busy     = (st_q != ST_IDLE);
   assign ready    = ready_q;

endmodule

// File: rtl/sdr_init_refresh_chk.sv
module sdr_init_refresh_chk #(
   parameter int ADDR_W   = 12,
   parameter int AP_BIT   = 10,
   parameter int TRFC_CYC = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              grant,
   input logic              sr_exit,
   input logic              cmd_req,
   input logic [3:0]        cmd_code,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              busy,
   input logic              ready
);

   localparam int SC_W = $clog2(TRFC_CYC + 2);
   localparam logic [SC_W-1:0] SC_MAX = SC_W'(TRFC_CYC + 1);

   logic [SC_W-1:0] since_q;
   logic            last_ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q    <= SC_MAX;
         last_ref_q <= 1'b0;
      end else if (cmd_req && grant) begin
         since_q    <= '0;
         last_ref_q <= (cmd_code == 4'b0001);
      end else if (since_q != SC_MAX) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R4
   r4_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !grant |=> cmd_req && $stable(cmd_code) && $stable(cmd_addr));

   // R3
   r3_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && cmd_code == 4'b0010 |-> cmd_addr[AP_BIT]);

   // R5
   r5_refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && last_ref_q |-> since_q >= SC_W'(TRFC_CYC));

   // R7
   r7_ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R7
   r7_busy_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> busy);

   // R10
   r10_exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_exit && ready && !busy |=> busy && !cmd_req);

   // R11
   r11_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_req |-> cmd_code == 4'b0111 && cmd_addr == '0);

endmodule

bind sdr_init_refresh_seq sdr_init_refresh_chk #(
   .ADDR_W   (ADDR_W),
   .AP_BIT   (AP_BIT),
   .TRFC_CYC (TRFC_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant    (grant),
   .sr_exit  (sr_exit),
   .cmd_req  (cmd_req),
   .cmd_code (cmd_code),
   .cmd_addr (cmd_addr),
   .busy     (busy),
   .ready    (ready)
);

// File: tb/sim_sdr_init_refresh_seq.sv
module sim_sdr_init_refresh_seq;

   localparam int AW    = 12;
   localparam int AP    = 10;
   localparam int NREF  = 2;
   localparam int MAXO  = 8;
   localparam int PWR   = 40;
   localparam int TRP   = 3;
   localparam int TRFC  = 5;
   localparam int TMRD  = 2;
   localparam int TXSR  = 6;
   localparam int REFI  = 100;
   localparam logic [AW-1:0] MODE = 12'h032;
   localparam int WDOG  = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mode_word = MODE;
   logic          grant = 1'b0;
   logic          sr_exit = 1'b0;
   logic          cmd_req;
   logic [3:0]    cmd_code;
   logic [AW-1:0] cmd_addr;
   logic          busy;
   logic          ready;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int t_ready = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdr_init_refresh_seq #(
      .ADDR_W    (AW),
      .AP_BIT    (AP),
      .INIT_REFS (NREF),
      .MAX_OWED  (MAXO),
      .PWRUP_CYC (PWR),
      .TRP_CYC   (TRP),
      .TRFC_CYC  (TRFC),
      .TMRD_CYC  (TMRD),
      .TXSR_CYC  (TXSR),
      .REFI_CYC  (REFI)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_word (mode_word),
      .grant     (grant),
      .sr_exit   (sr_exit),
      .cmd_req   (cmd_req),
      .cmd_code  (cmd_code),
      .cmd_addr  (cmd_addr),
      .busy      (busy),
      .ready     (ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // waits with grant high until the next request; returns low cycles since issue cycle e
   task automatic next_req(input int e, output int gap);
      do @(negedge clk); while (!cmd_req && cyc < WDOG);
      gap = cyc - e - 1;
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk(cmd_req == 1'b0, "R1 req", cmd_req, 0);
      chk(cmd_code == 4'b0111, "R1 code", cmd_code, 7);
      chk(cmd_addr == '0, "R1 addr", cmd_addr, 0);
      chk(busy == 1'b1 && ready == 1'b0, "R1 busy/ready", {busy, ready}, 2);
   endtask

   task automatic t_init_sequence();
      int c0, e, gap, bad;
      logic [3:0] c_hold;
      logic [AW-1:0] a_hold;
      bad = 0;
      rst_n = 1'b1;
      grant = 1'b0;
      c0 = cyc;
      while (!cmd_req && cyc < c0 + PWR + 10) begin
         if (cmd_code != 4'b0111) bad++;
         sr_exit = (cyc == c0 + 5);
         @(negedge clk);
      end
      sr_exit = 1'b0;
      // R2: quiet power-up window, sr_exit ignored
      chk(cyc - c0 == PWR, "R2 power-up length", cyc - c0, PWR);
      chk(bad == 0, "R2 bus quiet", bad, 0);
      // R3
      chk(cmd_code == 4'b0010, "R3 code", cmd_code, 2);
      chk(cmd_addr == AW'(1 << AP), "R3 addr", cmd_addr, 1 << AP);
      // R4: hold until granted
      c_hold = cmd_code;
      a_hold = cmd_addr;
      bad = 0;
      repeat (4) begin
         @(negedge clk);
         if (!cmd_req || cmd_code != c_hold || cmd_addr != a_hold) bad++;
      end
      chk(bad == 0, "R4 request held", bad, 0);
      grant = 1'b1;
      e = cyc;
      // R5
      next_req(e, gap);
      chk(gap == TRP, "R5 precharge wait", gap, TRP);
      chk(cmd_code == 4'b0001, "R5 first refresh", cmd_code, 1);
      e = cyc;
      next_req(e, gap);
      chk(gap == TRFC, "R5 refresh wait 1", gap, TRFC);
      chk(cmd_code == 4'b0001, "R5 second refresh", cmd_code, 1);
      e = cyc;
      next_req(e, gap);
      chk(gap == TRFC, "R5 refresh wait 2", gap, TRFC);
      // R6
      chk(cmd_code == 4'b0000, "R6 load mode code", cmd_code, 0);
      chk(cmd_addr == MODE, "R6 mode value", cmd_addr, MODE);
      e = cyc;
      do @(negedge clk); while (!ready && cyc < WDOG);
      // R7
      chk(cyc - e == TMRD + 1, "R7 ready timing", cyc - e, TMRD + 1);
      chk(busy == 1'b0 && cmd_req == 1'b0, "R7 busy falls", busy, 0);
      t_ready = cyc;
   endtask

   task automatic t_periodic();
      int p;
      do @(negedge clk); while (!cmd_req && cyc < WDOG);
      // R8
      chk(cyc - t_ready == REFI + 1, "R8 first periodic", cyc - t_ready, REFI + 1);
      chk(cmd_code == 4'b0001, "R8 code", cmd_code, 1);
      p = cyc;
      do @(negedge clk); while (cmd_req && cyc < WDOG);
      do @(negedge clk); while (!cmd_req && cyc < WDOG);
      chk(cyc - p == REFI, "R8 interval", cyc - p, REFI);
      chk(ready == 1'b1, "R7 ready stays", ready, 1);
   endtask

   task automatic t_saturate();
      int n_iss, last, bad, stop;
      grant = 1'b0;
      repeat (12 * REFI) @(negedge clk);
      chk(cmd_req == 1'b1 && busy == 1'b1, "R9 pending held", cmd_req, 1);
      while (((cyc - t_ready) % REFI) != 1) @(negedge clk);
      grant = 1'b1;
      n_iss = 0;
      last = 0;
      bad = 0;
      stop = cyc + 70;
      while (cyc < stop) begin
         if (cmd_req) begin
            if (n_iss > 0 && cyc - last != TRFC + 2) bad++;
            n_iss++;
            last = cyc;
         end
         @(negedge clk);
      end
      // R9
      chk(n_iss == MAXO, "R9 owed count", n_iss, MAXO);
      chk(bad == 0, "R9 back-to-back spacing", bad, 0);
   endtask

   task automatic t_self_refresh_exit();
      int s, bad;
      bad = 0;
      while ((busy || cmd_req) && cyc < WDOG) @(negedge clk);
      sr_exit = 1'b1;
      s = cyc;
      @(negedge clk);
      sr_exit = 1'b0;
      while (cyc <= s + TXSR) begin
         if (!busy || cmd_req) bad++;
         @(negedge clk);
      end
      // R10
      chk(bad == 0, "R10 exit window quiet", bad, 0);
      chk(busy == 1'b0, "R10 busy falls", busy, 0);
      do @(negedge clk); while (!cmd_req && cyc < WDOG);
      chk(cyc - s == REFI + 2, "R10 pacing restart", cyc - s, REFI + 2);
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      // R7: ready holds only until reset
      chk(ready == 1'b0 && busy == 1'b1, "R7 cleared by reset", ready, 0);
   endtask

   initial begin
      while (cyc < WDOG) @(negedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_state();
      t_init_sequence();
      t_periodic();
      t_saturate();
      t_self_refresh_exit();
      t_reset_again();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule